// File: doc/BRIEF.md
# Serial Bias Configuration Chain

This block is the digital programming path for a bank of on-chip programmable bias current generators. An external controller drives a slow bias clock and a serial data line. Each rising edge of the bias clock moves one bit into a long shift chain. The chain holds one 24-bit tap-select word for each bias, then a 4-bit test field, then an 8-bit buffer-bias field.

A level-sensitive hold stage copies the chain to parallel outputs while its active-low enable is low, and freezes them while it is high. The controller normally shifts a complete image with the enable high and then pulses it low once. The bit leaving the far end of the chain is driven out, so the controller can read the image back or pass it to a further chip.

An active-high power-down input forces every tap-select output and every drive-enable to zero. The per-bias drive-enable also drops whenever the latched buffer-bias field is zero, because no bias voltage can then be buffered out.

Top module: `bias_cfg_chain`

## Requirements
- R1: The chain is NUM_BIAS*24+12 bits long, with NUM_BIAS defaulting to 12. Each bias owns 24 consecutive bits, and `bias_code_o` carries all bias words as a parallel image.
- R2: A 1 shifted into a tap position appears as 1 (tap on) on the matching bit of `bias_code_o`, and a 0 appears as 0 (tap off).
- R3: Bits enter the chain at bit 0 on each rising edge of `clk_i`, and every bit moves up one place. After a full load, the first bit shifted in is bit 23 of bias 0, which is the farthest from the input and sits in the top 24 bits of `bias_code_o`. The last bias bit shifted in is bit 0 of bias NUM_BIAS-1, which is bit 0 of `bias_code_o`.
- R4: While `latch_ni` is low the outputs follow the chain. While it is high they hold their last values, whatever is shifted.
- R5: `sdata_o` is the top chain bit. During a full reload it returns the previous image in the order that image was shifted in.
- R6: The 12 bits shifted after the bias words hold 4 test bits, shifted first and seen on `test_o`, then 8 buffer-bias bits, shifted last and seen on `buf_code_o`. Both fields are MSB first.
- R7: While `pwr_dn_i` is high, `bias_code_o` and `drive_en_o` are all zero. Loading and latching still go on, and the latched values reappear once `pwr_dn_i` falls.
- R8: `drive_en_o` is all ones when the latched buffer-bias value is nonzero and power-down is low. Otherwise it is all zero. `bias_code_o` is not affected by the buffer-bias value.
- R9: `rst_ni` low clears the hold stage, so all parallel outputs read zero. The shift stages have no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bias shift clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset of the hold stage |
| sdata_i | input | 1 | Serial configuration data |
| latch_ni | input | 1 | Hold-stage enable: 0 transparent, 1 opaque |
| pwr_dn_i | input | 1 | Active-high power-down override |
| sdata_o | output | 1 | Bit leaving the last chain stage |
| bias_code_o | output | NUM_BIAS*24 | Tap-select words; bias 0 in the top 24 bits |
| test_o | output | 4 | Latched test/debug field |
| buf_code_o | output | 8 | Latched buffer-bias field |
| drive_en_o | output | NUM_BIAS | Per-bias drive enable |

## Verification
Distinct pseudo-random images per bias separate correct word placement from swapped or shifted slices. Single-one images at the first and last bias bit pin down the bit order at both ends of the chain, and an all-ones image exposes any stuck or dropped tap. A reload read back through the serial output shows the image leaves in the order it went in. Images with a zero and a nonzero buffer field, loaded with power-down low and high, separate the drive-enable qualifier from the power-down override.

// File: rtl/bias_cfg_pkg.sv
package bias_cfg_pkg;
  localparam int unsigned BIAS_W = 24;
  localparam int unsigned TEST_W = 4;
  localparam int unsigned BUF_W  = 8;

  function automatic int unsigned chain_len(input int unsigned nb);
    return nb * BIAS_W + TEST_W + BUF_W;
  endfunction
endpackage

// File: rtl/bias_shift_chain.sv
module bias_shift_chain #(
  parameter int unsigned LEN = 300
) (
  input  logic           clk_i,
  input  logic           sdata_i,
  output logic [LEN-1:0] chain_o,
  output logic           sdata_o
);
  logic [LEN-1:0] sr_q;

  // no reset: contents are don't-care until a full image is loaded
  always_ff @(posedge clk_i) begin
    sr_q <= {sr_q[LEN-2:0], sdata_i};
  end

  assign chain_o = sr_q;
  assign sdata_o = sr_q[LEN-1];
endmodule

// File: rtl/bias_latch_bank.sv
module bias_latch_bank #(
  parameter int unsigned LEN = 300
) (
  input  logic           rst_ni,
  input  logic           latch_ni,
  input  logic [LEN-1:0] d_i,
  output logic [LEN-1:0] q_o
);
  logic [LEN-1:0] hold_q;

  always_latch begin
    if (!rst_ni)        hold_q = '0;
    else if (!latch_ni) hold_q = d_i;
  end

  assign q_o = hold_q;
endmodule

// File: rtl/bias_out_gate.sv
module bias_out_gate #(
  parameter int unsigned NUM_BIAS = 12,
  parameter int unsigned BIAS_W   = 24,
  parameter int unsigned BUF_W    = 8,
  localparam int unsigned VEC_W   = NUM_BIAS * BIAS_W
) (
  input  logic                pwr_dn_i,
  input  logic [VEC_W-1:0]    words_i,
  input  logic [BUF_W-1:0]    buf_i,
  output logic [VEC_W-1:0]    bias_code_o,
  output logic [NUM_BIAS-1:0] drive_en_o
);
  logic buf_live;
  assign buf_live = |buf_i;

  for (genvar g = 0; g < NUM_BIAS; g++) begin : g_bias
    assign bias_code_o[g*BIAS_W +: BIAS_W] = pwr_dn_i ? '0 : words_i[g*BIAS_W +: BIAS_W];
    assign drive_en_o[g] = buf_live & ~pwr_dn_i;
  end
endmodule

// File: rtl/bias_cfg_chain.sv
module bias_cfg_chain
  import bias_cfg_pkg::*;
#(
  parameter int unsigned NUM_BIAS = 12,
  localparam int unsigned VEC_W   = NUM_BIAS * BIAS_W,
  localparam int unsigned LEN     = VEC_W + TEST_W + BUF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sdata_i,
  input  logic                latch_ni,
  input  logic                pwr_dn_i,
  output logic                sdata_o,
  output logic [VEC_W-1:0]    bias_code_o,
  output logic [TEST_W-1:0]   test_o,
  output logic [BUF_W-1:0]    buf_code_o,
  output logic [NUM_BIAS-1:0] drive_en_o
);
  logic [LEN-1:0] chain;
  logic [LEN-1:0] held;

  bias_shift_chain #(.LEN(LEN)) u_chain (
    .clk_i   (clk_i),
    .sdata_i (sdata_i),
    .chain_o (chain),
    .sdata_o (sdata_o)
  );

  bias_latch_bank #(.LEN(LEN)) u_hold (
    .rst_ni   (rst_ni),
    .latch_ni (latch_ni),
    .d_i      (chain),
    .q_o      (held)
  );

  // field layout: [bias words | test | buffer], buffer nearest the input
  bias_out_gate #(.NUM_BIAS(NUM_BIAS), .BIAS_W(BIAS_W), .BUF_W(BUF_W)) u_gate (
    .pwr_dn_i    (pwr_dn_i),
    .words_i     (held[LEN-1 -: VEC_W]),
    .buf_i       (held[BUF_W-1:0]),
    .bias_code_o (bias_code_o),
    .drive_en_o  (drive_en_o)
  );

  assign test_o     = held[BUF_W +: TEST_W];
  assign buf_code_o = held[BUF_W-1:0];
endmodule

// File: rtl/bias_cfg_chain_chk.sv
module bias_cfg_chain_chk #(
  parameter int unsigned NUM_BIAS = 12,
  parameter int unsigned BIAS_W   = 24,
  parameter int unsigned LEN      = 300,
  localparam int unsigned VEC_W   = NUM_BIAS * BIAS_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sdata_i,
  input logic                latch_ni,
  input logic                pwr_dn_i,
  input logic                sdata_o,
  input logic [VEC_W-1:0]    bias_code_o,
  input logic [7:0]          buf_code_o,
  input logic [NUM_BIAS-1:0] drive_en_o,
  input logic [LEN-1:0]      chain_i
);
  logic started;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  a_r3_lsb_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> chain_i[0] == $past(sdata_i));

  a_r5_serial_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started |-> sdata_o == $past(chain_i[LEN-2]));

  a_r4_transparent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_ni && !pwr_dn_i) |-> bias_code_o == chain_i[LEN-1 -: VEC_W]);

  a_r7_pd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |-> (bias_code_o == '0 && drive_en_o == '0));

  a_r8_buf_zero_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_code_o == '0) |-> drive_en_o == '0);

  always_comb begin
    if (!rst_ni) a_r9_reset_clear: assert (bias_code_o == '0 && buf_code_o == '0);
  end
endmodule

bind bias_cfg_chain bias_cfg_chain_chk #(
  .NUM_BIAS(NUM_BIAS), .BIAS_W(BIAS_W), .LEN(LEN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sdata_i     (sdata_i),
  .latch_ni    (latch_ni),
  .pwr_dn_i    (pwr_dn_i),
  .sdata_o     (sdata_o),
  .bias_code_o (bias_code_o),
  .buf_code_o  (buf_code_o),
  .drive_en_o  (drive_en_o),
  .chain_i     (chain)
);

// File: tb/tb_bias_cfg_chain.sv
module tb_bias_cfg_chain;
  localparam int NB = 12;
  localparam int W  = 24;
  localparam int TW = 4;
  localparam int BW = 8;
  localparam int VB = NB * W;
  localparam int L  = VB + TW + BW;

  logic clk = 1'b0, sh_en = 1'b0, rst_n = 1'b0;
  logic sdi = 1'b0, latch_n = 1'b1, pd = 1'b0;
  logic bias_clk;
  logic sdo;
  logic [VB-1:0] code;
  logic [TW-1:0] tst;
  logic [BW-1:0] bufc;
  logic [NB-1:0] den;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign bias_clk = clk & sh_en;

  bias_cfg_chain #(.NUM_BIAS(NB)) dut (
    .clk_i(bias_clk), .rst_ni(rst_n), .sdata_i(sdi), .latch_ni(latch_n),
    .pwr_dn_i(pd), .sdata_o(sdo), .bias_code_o(code), .test_o(tst),
    .buf_code_o(bufc), .drive_en_o(den)
  );

  task automatic chk(input bit ok, input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] mk_img(input int seed, input logic [TW-1:0] t, input logic [BW-1:0] b);
    logic [L-1:0] img;
    for (int k = 0; k < NB; k++)
      img[L-1-k*W -: W] = W'((32'h005A5A17 * (k + 1)) ^ (seed * 32'h00011F3D) ^ (k << 9));
    img[BW +: TW] = t;
    img[BW-1:0]   = b;
    return img;
  endfunction

  // shifts img MSB first; optionally compares sdata_o with the previous image
  task automatic load(input logic [L-1:0] img, input bit cmp, input logic [L-1:0] prev, output int mism);
    mism = 0;
    for (int i = L - 1; i >= 0; i--) begin
      @(negedge clk);
      sdi = img[i];
      sh_en = 1'b1;
      #1;
      if (cmp && sdo !== prev[i]) mism++;
    end
    @(negedge clk);
    sh_en = 1'b0;
  endtask

  task automatic pulse_latch();
    @(negedge clk); latch_n = 1'b0;
    @(negedge clk); latch_n = 1'b1;
    @(negedge clk);
  endtask

  logic [L-1:0] img_a, img_b;

  task automatic t_reset();
    @(negedge clk);
    chk(code === '0, "R9 bias code at reset", L'(code), '0);
    chk(bufc === '0 && tst === '0 && den === '0, "R9 fields at reset", L'({tst, bufc, den}), '0);
  endtask

  task automatic t_opaque_load();
    int m;
    img_a = mk_img(3, 4'hA, 8'h5C);
    load(img_a, 1'b0, '0, m);
    chk(code === '0, "R4 opaque during shift", L'(code), '0);
    chk(sdo === img_a[L-1], "R5 first bit at chain end", L'(sdo), L'(img_a[L-1]));
    pulse_latch();
    chk(code === img_a[L-1 -: VB], "R1 R3 bias words placed", L'(code), L'(img_a[L-1 -: VB]));
    chk(tst === 4'hA, "R6 test field", L'(tst), L'(4'hA));
    chk(bufc === 8'h5C, "R6 buffer field", L'(bufc), L'(8'h5C));
    chk(den === '1, "R8 drive enable on", L'(den), L'({NB{1'b1}}));
  endtask

  task automatic t_chain_out();
    int m;
    img_b = mk_img(77, 4'h3, 8'h81);
    load(img_b, 1'b1, img_a, m);
    chk(m == 0, "R5 readback mismatches", L'(m), '0);
    chk(code === img_a[L-1 -: VB], "R4 hold old image", L'(code), L'(img_a[L-1 -: VB]));
    pulse_latch();
    chk(code === img_b[L-1 -: VB] && tst === 4'h3, "R4 new image latched", L'(code), L'(img_b[L-1 -: VB]));
  endtask

  task automatic t_order();
    int m;
    logic [L-1:0] img;
    img = '0; img[L-1] = 1'b1; img[0] = 1'b1;
    load(img, 1'b0, '0, m); pulse_latch();
    chk(code === {1'b1, {(VB-1){1'b0}}}, "R3 first bit is msb of bias 0", L'(code), L'({1'b1, {(VB-1){1'b0}}}));
    img = '0; img[BW+TW] = 1'b1; img[0] = 1'b1;
    load(img, 1'b0, '0, m); pulse_latch();
    chk(code === VB'(1), "R3 last bias bit is lsb of last bias", L'(code), L'(1));
    img = '1;
    load(img, 1'b0, '0, m); pulse_latch();
    chk(code === '1 && tst === '1 && bufc === '1, "R2 all taps on", L'(code), L'({VB{1'b1}}));
  endtask

  task automatic t_buf_zero();
    int m;
    logic [L-1:0] img;
    img = mk_img(9, 4'h0, 8'h00);
    load(img, 1'b0, '0, m); pulse_latch();
    chk(den === '0, "R8 zero buffer disables drive", L'(den), '0);
    chk(code === img[L-1 -: VB], "R8 code kept with zero buffer", L'(code), L'(img[L-1 -: VB]));
    img = mk_img(9, 4'h0, 8'h01);
    load(img, 1'b0, '0, m); pulse_latch();
    chk(den === '1, "R8 buffer one enables drive", L'(den), L'({NB{1'b1}}));
  endtask

  task automatic t_pd();
    int m;
    logic [L-1:0] img;
    img = mk_img(21, 4'h6, 8'h40);
    load(img, 1'b0, '0, m); pulse_latch();
    @(negedge clk); pd = 1'b1; #1;
    chk(code === '0 && den === '0, "R7 power-down zeroes outputs", L'({code, den}), '0);
    img_b = mk_img(55, 4'h9, 8'h10);
    load(img_b, 1'b0, '0, m); pulse_latch();
    chk(code === '0 && den === '0, "R7 zero after load in power-down", L'({code, den}), '0);
    pd = 1'b0; #1;
    chk(code === img_b[L-1 -: VB] && den === '1, "R7 restored after power-down", L'(code), L'(img_b[L-1 -: VB]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_opaque_load();
    t_chain_out();
    t_order();
    t_buf_zero();
    t_pd();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule